// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes one memory request from a 32-lane warp and turns it into aligned global-memory transactions. The request carries one byte address per lane, a mask of active lanes and a load/store flag. Each lane reads or writes one 4-byte word. Every transaction is either a 32-byte sector or a 128-byte segment, aligned to its own size. Each transaction carries its base address, a size code and the mask of the lanes it serves.

The block accepts a request only while it is idle. It then sends the transactions one at a time over a valid/ready handshake. It always starts from the lowest-numbered lane that has not yet been served. That lane picks the window: a 128-byte segment when other pending lanes fall in a different sector of the same segment, otherwise a 32-byte sector. After each handshake the lanes that were served are cleared from the pending set. One cycle after the last handshake, `done` pulses for one cycle.

A warp whose lanes access adjacent words therefore needs one or two transactions. Scattered lanes can need one transaction per lane.

Top module: `warp_coalescer`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `txn_valid` and `done` are 0.
- R2: A request is captured only on a cycle with `req_valid` and `req_ready` both high. `req_ready` is 1 only while idle. A request offered while the block is busy or finishing has no effect on the transactions in flight.
- R3: A request with an all-zero lane mask produces no transaction. `done` is 1 in the cycle after the request is accepted.
- R4: Each transaction is built around the lowest-numbered lane that is still pending, and that lane is in its mask.
- R5: If every pending lane in the leading lane's 128-byte segment lies in the leading lane's 32-byte sector, the transaction is small. `txn_big` is 0, and `txn_base` is the leading lane's address with bits [4:0] cleared.
- R6: If some pending lane lies in the same 128-byte segment but a different 32-byte sector, the transaction is large. `txn_big` is 1, `txn_base` is the leading address with bits [6:0] cleared, and the mask holds every pending lane of that segment.
- R7: A transaction's mask holds exactly the pending lanes whose addresses fall inside its window. Served lanes are cleared after each handshake, so every active lane is served exactly once and the number of transactions equals the number of distinct windows chosen.
- R8: While `txn_valid` is high and `txn_ready` is low, `txn_base`, `txn_big`, `txn_mask` and `txn_store` stay unchanged.
- R9: `done` is high for exactly one cycle: the cycle after the last handshake. The block is idle (`req_ready` = 1) in the following cycle.
- R10: The addresses of inactive lanes have no effect on the size, base or mask of any transaction.
- R11: `txn_store` equals the `req_store` value captured with the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Warp request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 1024 | Lane byte addresses; lane i occupies bits [32*i+31:32*i] |
| req_mask | input | 32 | Active-lane mask; bit i is lane i |
| req_store | input | 1 | 1 for a store, 0 for a load |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_base | output | 32 | Aligned base byte address |
| txn_big | output | 1 | Size code: 0 for 32 bytes, 1 for 128 bytes |
| txn_mask | output | 32 | Lanes served by this transaction |
| txn_store | output | 1 | Load/store flag of the request |
| done | output | 1 | One-cycle pulse marking the end of a request |

## Verification
The last handshake of a request and the completion decision happen in the same cycle. In that cycle the pending set empties and the block has to move to its finishing state without offering another transaction. The bench provokes this while holding a second, different request on the input for the whole busy period. It also inserts ready stalls before every handshake. It then checks three things: `done` appears exactly one cycle after the final handshake, `txn_valid` is low at that point, and the second request is not captured before the block reports idle.

// File: rtl/warp_coal_pkg.sv
// Shared types for the warp coalescer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package warp_coal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_FIN  = 2'd2
    } coal_state_e;

    localparam logic SZ_SMALL = 1'b0;
    localparam logic SZ_LARGE = 1'b1;
endpackage

// File: rtl/lane_picker.sv
// Finds the lowest-numbered set bit of a lane vector.
// Assumes: the caller ignores idx when vec is all zero (idx is then 0).
module lane_picker #(
    parameter int N     = 32,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic [IDX_W-1:0] idx
);
    // Priority scan, highest first so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/seg_matcher.sv
// Compares every pending lane's address with the leading lane's address at
// sector and segment granularity.
// Assumes: the sector and segment sizes are powers of two, with the segment
// no smaller than the sector.
module seg_matcher #(
    parameter int LANES    = 32,
    parameter int ADDR_W   = 32,
    parameter int SECT_LSB = 5,
    parameter int SEG_LSB  = 7,
    localparam int IDX_W   = $clog2(LANES)
) (
    input  logic [LANES*ADDR_W-1:0] addr_flat,
    input  logic [LANES-1:0]        pending,
    input  logic [IDX_W-1:0]        lead_idx,
    output logic [ADDR_W-1:0]       lead_addr,
    output logic [LANES-1:0]        seg_hit,
    output logic [LANES-1:0]        sect_hit
);
    // Select the leading lane's address.
    always_comb begin
        lead_addr = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lead_idx == IDX_W'(i)) lead_addr = addr_flat[i*ADDR_W +: ADDR_W];
        end
    end

    // One comparator pair per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [ADDR_W-1:0] diff;
        assign diff        = addr_flat[g*ADDR_W +: ADDR_W] ^ lead_addr;
        assign seg_hit[g]  = pending[g] && ((diff >> SEG_LSB) == '0);
        assign sect_hit[g] = pending[g] && ((diff >> SECT_LSB) == '0);
    end
endmodule

// File: rtl/warp_coalescer.sv
// Turns one warp request into a sequence of aligned 32-byte or 128-byte
// transactions. Each transaction carries a base address, a size code and a
// lane mask.
// Assumes: 4-byte lane accesses; downstream follows valid/ready rules.
module warp_coalescer
    import warp_coal_pkg::*;
#(
    parameter int LANES       = 32,
    parameter int ADDR_W      = 32,
    parameter int SMALL_BYTES = 32,
    parameter int LARGE_BYTES = 128,
    localparam int SECT_LSB   = $clog2(SMALL_BYTES),
    localparam int SEG_LSB    = $clog2(LARGE_BYTES),
    localparam int IDX_W      = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]        req_mask,
    input  logic                    req_store,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [ADDR_W-1:0]       txn_base,
    output logic                    txn_big,
    output logic [LANES-1:0]        txn_mask,
    output logic                    txn_store,
    output logic                    done
);
    coal_state_e             state_q;
    logic [LANES*ADDR_W-1:0] addr_q;
    logic [LANES-1:0]        pending_q;
    logic                    store_q;

    logic [IDX_W-1:0]        lead_idx;
    logic [ADDR_W-1:0]       lead_addr;
    logic [LANES-1:0]        seg_hit;
    logic [LANES-1:0]        sect_hit;
    logic [LANES-1:0]        remain;

    lane_picker #(.N(LANES)) picker_i (
        .vec (pending_q),
        .idx (lead_idx)
    );

    seg_matcher #(
        .LANES(LANES), .ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB), .SEG_LSB(SEG_LSB)
    ) matcher_i (
        .addr_flat (addr_q),
        .pending   (pending_q),
        .lead_idx  (lead_idx),
        .lead_addr (lead_addr),
        .seg_hit   (seg_hit),
        .sect_hit  (sect_hit)
    );

    // Size choice, base alignment and served-lane mask.
    always_comb begin
        txn_big  = (|(seg_hit & ~sect_hit)) ? SZ_LARGE : SZ_SMALL;
        txn_mask = txn_big ? seg_hit : sect_hit;
        txn_base = txn_big ? (lead_addr & ~ADDR_W'(LARGE_BYTES - 1))
                           : (lead_addr & ~ADDR_W'(SMALL_BYTES - 1));
        remain   = pending_q & ~txn_mask;
    end

    assign req_ready = (state_q == ST_IDLE);
    assign txn_valid = (state_q == ST_BUSY);
    assign done      = (state_q == ST_FIN);
    assign txn_store = store_q;

    // Request capture, pending-lane retirement and sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            addr_q    <= '0;
            pending_q <= '0;
            store_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    addr_q    <= req_addr;
                    pending_q <= req_mask;
                    store_q   <= req_store;
                    state_q   <= (|req_mask) ? ST_BUSY : ST_FIN;
                end
                ST_BUSY: if (txn_ready) begin
                    pending_q <= remain;
                    if (remain == '0) state_q <= ST_FIN;
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R8: an offered transaction is held while stalled.
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && !txn_ready |=> txn_valid && $stable(txn_base) &&
        $stable(txn_mask) && $stable(txn_big) && $stable(txn_store));

    // R7: a mask is non-empty and draws only on pending lanes.
    a_r7_mask_subset: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_mask != '0) && ((txn_mask & ~pending_q) == '0));

    // R7: served lanes leave the pending set.
    a_r7_lanes_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && txn_ready |=> (pending_q & $past(txn_mask)) == '0);

    // R4: the lowest pending lane is always covered.
    a_r4_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((pending_q & (~pending_q + 1'b1)) & txn_mask) != '0);

    // R3: an empty request finishes at once.
    a_r3_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && (req_mask == '0) |=> done && !txn_valid);

    // R9: done is a single-cycle pulse followed by idle.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready);

    // R2: captured request state does not move while busy.
    a_r2_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> $stable(store_q) && $stable(addr_q));

    // R5/R6: each served lane's address lies inside the transaction window.
    for (genvar g = 0; g < LANES; g++) begin : g_chk
        a_r6_lane_in_window: assert property (@(posedge clk) disable iff (!rst_n)
            txn_valid && txn_mask[g] |->
            ((addr_q[g*ADDR_W +: ADDR_W] & ~ADDR_W'(txn_big ? LARGE_BYTES - 1
                                                             : SMALL_BYTES - 1))
             == txn_base));
    end
endmodule

// File: tb/warp_coalescer_tb_top.sv
// Directed bench for warp_coalescer; a scoreboard model derived from the
// requirements predicts every transaction.
module warp_coalescer_tb_top;
    localparam int LANES = 32;
    localparam int AW    = 32;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_valid = 1'b0;
    logic                 req_ready;
    logic [LANES*AW-1:0]  req_addr = '0;
    logic [LANES-1:0]     req_mask = '0;
    logic                 req_store = 1'b0;
    logic                 txn_valid;
    logic                 txn_ready = 1'b0;
    logic [AW-1:0]        txn_base;
    logic                 txn_big;
    logic [LANES-1:0]     txn_mask;
    logic                 txn_store;
    logic                 done;

    int checks = 0;
    int errors = 0;

    logic [AW-1:0]    m_addr [LANES];
    logic [LANES-1:0] m_mask;
    logic             m_store;

    always #5 clk = ~clk;

    warp_coalescer dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_mask(req_mask), .req_store(req_store),
        .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_base(txn_base),
        .txn_big(txn_big), .txn_mask(txn_mask), .txn_store(txn_store),
        .done(done)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference prediction: window chosen from the lowest pending lane.
    task automatic predict(input logic [LANES-1:0] pend, output logic [AW-1:0] base,
                           output logic big, output logic [LANES-1:0] msk);
        int lead = 0;
        logic [LANES-1:0] seg = '0;
        logic [LANES-1:0] sec = '0;
        for (int i = LANES - 1; i >= 0; i--) if (pend[i]) lead = i;
        for (int i = 0; i < LANES; i++) begin
            if (pend[i] && (m_addr[i] / 128 == m_addr[lead] / 128)) seg[i] = 1'b1;
            if (pend[i] && (m_addr[i] / 32  == m_addr[lead] / 32))  sec[i] = 1'b1;
        end
        big  = (seg != sec);
        msk  = big ? seg : sec;
        base = big ? (m_addr[lead] / 128) * 128 : (m_addr[lead] / 32) * 32;
    endtask

    // Drives one request and checks every transaction plus completion.
    task automatic run_req(input int exp_n, input int stall, input bit hold_other);
        logic [LANES-1:0] pend = m_mask;
        logic [AW-1:0]    e_base;
        logic             e_big;
        logic [LANES-1:0] e_mask;
        int n = 0;
        @(negedge clk);
        chk("R2 idle ready", 64'(req_ready), 64'd1);
        for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = m_addr[i];
        req_mask  = m_mask;
        req_store = m_store;
        req_valid = 1'b1;
        @(negedge clk);
        if (hold_other) begin
            for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = 32'h00F0_0000 + 32'(i) * 512;
            req_mask  = '1;
            req_store = ~m_store;
        end else begin
            req_valid = 1'b0;
        end
        while (pend != '0 && n < 40) begin
            predict(pend, e_base, e_big, e_mask);
            chk("R2 busy not ready", 64'(req_ready), 64'd0);
            chk("R7 txn valid", 64'(txn_valid), 64'd1);
            chk("R4/R7 txn mask", 64'(txn_mask), 64'(e_mask));
            chk("R5/R6 txn base", 64'(txn_base), 64'(e_base));
            chk("R5/R6 txn size", 64'(txn_big), 64'(e_big));
            chk("R11 txn store", 64'(txn_store), 64'(m_store));
            for (int s = 0; s < stall; s++) begin
                txn_ready = 1'b0;
                @(negedge clk);
                chk("R8 stalled base", 64'(txn_base), 64'(e_base));
                chk("R8 stalled mask", 64'(txn_mask), 64'(e_mask));
                chk("R8 stalled valid", 64'(txn_valid), 64'd1);
            end
            txn_ready = 1'b1;
            @(posedge clk);
            pend &= ~e_mask;
            n++;
            @(negedge clk);
            txn_ready = 1'b0;
        end
        chk("R7 txn count", 64'(n), 64'(exp_n));
        chk("R9/R3 done after last", 64'(done), 64'd1);
        chk("R9 no txn with done", 64'(txn_valid), 64'd0);
        @(negedge clk);
        chk("R9 done one cycle", 64'(done), 64'd0);
        chk("R9 idle after done", 64'(req_ready), 64'd1);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", 64'(req_ready), 64'd1);
        chk("R1 valid", 64'(txn_valid), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
    endtask

    task automatic t_contig_aligned();   // R6: one large transaction
        for (int i = 0; i < LANES; i++) m_addr[i] = 32'h1000 + 32'(i) * 4;
        m_mask = '1; m_store = 1'b0;
        run_req(1, 0, 0);
    endtask

    task automatic t_contig_offset();    // R6 then R5: segment crossing
        for (int i = 0; i < LANES; i++) m_addr[i] = 32'h1010 + 32'(i) * 4;
        m_mask = '1; m_store = 1'b1;
        run_req(2, 0, 0);
    endtask

    task automatic t_scattered();        // R5/R7: one per lane
        for (int i = 0; i < LANES; i++) m_addr[i] = 32'h4000 + 32'(i) * 256 + 32'(i % 4) * 4;
        m_mask = '1; m_store = 1'b0;
        run_req(32, 0, 0);
    endtask

    task automatic t_empty();            // R3
        for (int i = 0; i < LANES; i++) m_addr[i] = 32'(i) * 4;
        m_mask = '0; m_store = 1'b0;
        run_req(0, 0, 0);
    endtask

    task automatic t_inactive_ignored(); // R10: inactive lanes in other sectors
        for (int i = 0; i < LANES; i++) m_addr[i] = 32'h2040 + 32'(i % 4) * 4;
        for (int i = 4; i < 8; i++) m_addr[i] = 32'h2000 + 32'(i) * 4;
        m_mask = 32'h0000_00F0; m_store = 1'b1;
        run_req(1, 0, 0);
        chk("R10 seen small", 64'(txn_big), 64'd0);
    endtask

    task automatic t_order();            // R4: lane 0 first although higher address
        for (int i = 0; i < LANES; i++) m_addr[i] = 32'h9000;
        m_addr[0] = 32'h5000; m_addr[1] = 32'h4000; m_addr[2] = 32'h5004;
        m_mask = 32'h7; m_store = 1'b0;
        run_req(2, 0, 0);
    endtask

    task automatic t_backpressure();     // R8, R2, R9: stalls and held second request
        for (int i = 0; i < LANES; i++) m_addr[i] = 32'h3020 + 32'(i) * 8;
        m_mask = 32'hF0F0_FFFF; m_store = 1'b1;
        run_req(3, 2, 1);
        t_contig_aligned();
    endtask

    initial begin
        t_reset();
        t_contig_aligned();
        t_contig_offset();
        t_scattered();
        t_empty();
        t_inactive_ignored();
        t_order();
        t_backpressure();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule